// File: doc/BRIEF.md
# Interrupt Aggregation Controller

The block gathers a set of level-sensitive interrupt sources into one interrupt request for a processor. Each source line owns one bit of a status word: a rising level on the line sets the bit, a falling level clears it. An enable word masks the status, and the request output is high whenever any status bit that is also enabled is set. The output is registered, so it follows its cause by one clock.

Software reaches the block through a single-cycle register port with a four-bit word offset. Four registers are mapped. Offset 0x0 is status, with reads returning the raw status and writes clearing each bit written as one. Offset 0x1 is a status override that replaces the whole status word. Offset 0x2 is the enable mask. Offset 0x3 is a read-only view of status AND enable. Accesses that make no sense raise a one-cycle error flag. These are reads of the override, writes of the masked view, and any access to an unmapped offset.

When a source edge and a software write touch the same status bit in the same cycle, the source edge wins. A peripheral that numbers its interrupt with bit 0 as the most significant bit is wired to line (31 minus its number).

Top module: `irq_gather_ctrl`

## Requirements
- R1: Line i maps to status bit i (bit 0 least significant). A 0-to-1 change on line i sets status bit i at the next clock edge.
- R2: A 1-to-0 change on line i clears status bit i at the next clock edge.
- R3: `irq` is registered. After each clock edge it equals the OR-reduction of (status AND enable) as they stand after that edge.
- R4: A write to offset 0x0 clears every status bit whose write-data bit is 1 and leaves the other bits unchanged. A read of offset 0x0 returns the raw status.
- R5: A write to offset 0x1 replaces the status with the write data. A read of offset 0x1 returns the raw status and raises `bus_err`.
- R6: Offset 0x2 holds the enable mask. A write replaces it, and a read returns it.
- R7: A read of offset 0x3 returns status AND enable. A write to offset 0x3 changes neither status nor enable and raises `bus_err`.
- R8: Offsets 0x4 to 0xF read as zero, ignore writes, and raise `bus_err`.
- R9: If a source edge and a software write (offset 0x0 or 0x1) act on the same status bit in one cycle, the bit takes the value given by the source edge.
- R10: Reset clears status and enable and drives `irq` low.
- R11: `bus_err` is high, in the same cycle as the request, only for the illegal accesses named in R5, R7 and R8. It is low for every legal access and whenever `bus_valid` is low. `bus_rdata` is zero when no read is requested.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src | input | 32 | Level-sensitive interrupt source lines |
| bus_valid | input | 1 | Register access request this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | Register word offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, same cycle as the request |
| bus_err | output | 1 | Illegal access pulse, same cycle as the request |
| irq | output | 1 | Aggregated interrupt request to the processor |

## Verification
A status bit that is held wrong is seen in two ways. It shows on the next read of offset 0x0, 0x1 or 0x3. It also shows on `irq`, one edge after the bit goes wrong, whenever the matching enable bit is set. The stimulus therefore reads the registers often and keeps enable masks mixed, so that a wrong bit reaches the ports within a few cycles. A lost edge priority or a decode slip changes the next read of status or enable. The bench also checks `irq` after every edge.

// File: rtl/irqg_pkg.sv
`timescale 1ns/1ps
package irqg_pkg;
    typedef enum logic [2:0] {
        SEL_STAT,
        SEL_OVR,
        SEL_EN,
        SEL_MASK,
        SEL_NONE
    } reg_sel_e;

    localparam int OFS_STAT = 0;
    localparam int OFS_OVR  = 1;
    localparam int OFS_EN   = 2;
    localparam int OFS_MASK = 3;
endpackage

// File: rtl/irqg_decode.sv
`timescale 1ns/1ps
module irqg_decode
    import irqg_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    output reg_sel_e          sel,
    output logic              illegal,
    output logic              do_clr,
    output logic              do_ovr,
    output logic              do_en
);
    always_comb begin
        if (req_addr == ADDR_W'(OFS_STAT))      sel = SEL_STAT;
        else if (req_addr == ADDR_W'(OFS_OVR))  sel = SEL_OVR;
        else if (req_addr == ADDR_W'(OFS_EN))   sel = SEL_EN;
        else if (req_addr == ADDR_W'(OFS_MASK)) sel = SEL_MASK;
        else                                    sel = SEL_NONE;

        illegal = req_valid && ((sel == SEL_NONE)
                             || (sel == SEL_OVR  && !req_write)
                             || (sel == SEL_MASK &&  req_write));
        do_clr  = req_valid && req_write && (sel == SEL_STAT);
        do_ovr  = req_valid && req_write && (sel == SEL_OVR);
        do_en   = req_valid && req_write && (sel == SEL_EN);
    end
endmodule

// File: rtl/irqg_status.sv
`timescale 1ns/1ps
module irqg_status #(
    parameter int N_LINES = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [N_LINES-1:0] src_i,
    input  logic               clr_i,
    input  logic               ovr_i,
    input  logic [N_LINES-1:0] wdata_i,
    output logic [N_LINES-1:0] stat_o,
    output logic [N_LINES-1:0] stat_next_o
);
    typedef struct packed {
        logic [N_LINES-1:0] src_prev;
        logic [N_LINES-1:0] stat;
    } st_t;

    st_t st_d, st_q;
    logic [N_LINES-1:0] sw_val;
    logic [N_LINES-1:0] rise_w;
    logic [N_LINES-1:0] fall_w;

    always_comb begin
        st_d          = st_q;
        st_d.src_prev = src_i;
        rise_w        = src_i & ~st_q.src_prev;
        fall_w        = ~src_i & st_q.src_prev;
        if (clr_i)      sw_val = st_q.stat & ~wdata_i;
        else if (ovr_i) sw_val = wdata_i;
        else            sw_val = st_q.stat;
        // source edges take precedence over the software value
        st_d.stat     = (sw_val & ~(rise_w | fall_w)) | rise_w;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign stat_o      = st_q.stat;
    assign stat_next_o = st_d.stat;

    // R1 R9
    rise_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rise_w != '0) |=> ((stat_o & $past(rise_w)) == $past(rise_w)));

    // R2 R9
    fall_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fall_w != '0) |=> ((stat_o & $past(fall_w)) == '0));
endmodule

// File: rtl/irq_gather_ctrl.sv
`timescale 1ns/1ps
module irq_gather_ctrl
    import irqg_pkg::*;
#(
    parameter int N_LINES = 32,
    parameter int ADDR_W  = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [N_LINES-1:0] src,
    input  logic               bus_valid,
    input  logic               bus_write,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [N_LINES-1:0] bus_wdata,
    output logic [N_LINES-1:0] bus_rdata,
    output logic               bus_err,
    output logic               irq
);
    typedef struct packed {
        logic [N_LINES-1:0] enable;
        logic               irq;
    } ctl_t;

    ctl_t ctl_d, ctl_q;
    reg_sel_e sel;
    logic illegal, do_clr, do_ovr, do_en;
    logic [N_LINES-1:0] stat_q, stat_next;

    irqg_decode #(.ADDR_W(ADDR_W)) u_decode (
        .req_valid (bus_valid),
        .req_write (bus_write),
        .req_addr  (bus_addr),
        .sel       (sel),
        .illegal   (illegal),
        .do_clr    (do_clr),
        .do_ovr    (do_ovr),
        .do_en     (do_en)
    );

    irqg_status #(.N_LINES(N_LINES)) u_status (
        .clk         (clk),
        .rst_n       (rst_n),
        .src_i       (src),
        .clr_i       (do_clr),
        .ovr_i       (do_ovr),
        .wdata_i     (bus_wdata),
        .stat_o      (stat_q),
        .stat_next_o (stat_next)
    );

    always_comb begin
        ctl_d        = ctl_q;
        if (do_en) ctl_d.enable = bus_wdata;
        ctl_d.irq    = |(stat_next & ctl_d.enable);

        bus_rdata = '0;
        if (bus_valid && !bus_write) begin
            case (sel)
                SEL_STAT, SEL_OVR: bus_rdata = stat_q;
                SEL_EN:            bus_rdata = ctl_q.enable;
                SEL_MASK:          bus_rdata = stat_q & ctl_q.enable;
                default:           bus_rdata = '0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    assign bus_err = illegal;
    assign irq     = ctl_q.irq;

    // R3
    irq_tracks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq == (|(stat_q & ctl_q.enable)));

    // R7
    mask_write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && bus_write && bus_addr == ADDR_W'(OFS_MASK))
            |-> bus_err ##1 $stable(ctl_q.enable));

    // R8
    unmapped_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && !bus_write && bus_addr > ADDR_W'(OFS_MASK))
            |-> (bus_rdata == '0 && bus_err));

    // R11
    err_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_valid |-> (!bus_err && bus_rdata == '0));
endmodule

// File: tb/tb_irq_gather_ctrl.sv
`timescale 1ns/1ps
module tb_irq_gather_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] src = '0;
    logic        bus_valid = 1'b0;
    logic        bus_write = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        bus_err;
    logic        irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [31:0] m_stat = '0, m_en = '0, m_prev = '0;

    always #2 clk = ~clk;

    irq_gather_ctrl dut (
        .clk(clk), .rst_n(rst_n), .src(src),
        .bus_valid(bus_valid), .bus_write(bus_write), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_err(bus_err),
        .irq(irq)
    );

    function automatic logic [31:0] exp_rdata(logic v, logic w, logic [3:0] a);
        if (!v || w) return '0;
        case (a)
            4'h0, 4'h1: return m_stat;
            4'h2:       return m_en;
            4'h3:       return m_stat & m_en;
            default:    return '0;
        endcase
    endfunction

    function automatic logic exp_err(logic v, logic w, logic [3:0] a);
        return v && ((a > 4'h3) || (a == 4'h1 && !w) || (a == 4'h3 && w));
    endfunction

    function automatic string addr_tag(logic [3:0] a);
        case (a)
            4'h0: return "R4";
            4'h1: return "R5";
            4'h2: return "R6";
            4'h3: return "R7";
            default: return "R8";
        endcase
    endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic cyc(logic v, logic w, logic [3:0] a, logic [31:0] wd,
                       logic [31:0] s, string tag);
        logic [31:0] sw, rise, fall;
        @(negedge clk);
        bus_valid = v; bus_write = w; bus_addr = a; bus_wdata = wd; src = s;
        #1;
        chk((tag != "") ? tag : addr_tag(a), bus_rdata, exp_rdata(v, w, a));
        chk("R11", {31'b0, bus_err}, {31'b0, exp_err(v, w, a)});
        @(posedge clk);
        sw = m_stat;
        if (v && w && a == 4'h0) sw = m_stat & ~wd;
        else if (v && w && a == 4'h1) sw = wd;
        rise = s & ~m_prev;
        fall = ~s & m_prev;
        m_stat = (sw & ~(rise | fall)) | rise;
        m_prev = s;
        if (v && w && a == 4'h2) m_en = wd;
        #1;
        chk("R3", {31'b0, irq}, {31'b0, |(m_stat & m_en)});
    endtask

    initial begin
        #(200000 * 4);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R10: state after reset
        #1 chk("R10", {31'b0, irq}, 32'd0);
        cyc(1, 0, 4'h0, 0, 0, "R10");
        cyc(1, 0, 4'h2, 0, 0, "R10");
        // R1: line 5 rises, then read status
        cyc(0, 0, 4'h0, 0, 32'h20, "");
        cyc(1, 0, 4'h0, 0, 32'h20, "R1");
        // R6: enable bit 5, irq should rise (R3)
        cyc(1, 1, 4'h2, 32'h20, 32'h20, "");
        cyc(1, 0, 4'h2, 0, 32'h20, "R6");
        // R2: line 5 falls
        cyc(0, 0, 4'h0, 0, 0, "");
        cyc(1, 0, 4'h0, 0, 0, "R2");
        // R5: override write, then illegal read of override
        cyc(1, 1, 4'h1, 32'hA000_0021, 0, "");
        cyc(1, 0, 4'h1, 0, 0, "R5");
        // R4: write-one-to-clear bit 0 only
        cyc(1, 1, 4'h0, 32'h1, 0, "");
        cyc(1, 0, 4'h0, 0, 0, "R4");
        // R9: rise on line 7 during a clear of bit 7; rise on 9 during override 0
        cyc(1, 1, 4'h0, 32'hFFFF_FFFF, 32'h80, "");
        cyc(1, 0, 4'h0, 0, 32'h80, "R9");
        cyc(1, 1, 4'h1, 32'h0, 32'h280, "");
        cyc(1, 0, 4'h0, 0, 32'h280, "R9");
        // R9: fall on line 7 during an override that sets bit 7
        cyc(1, 1, 4'h1, 32'h80, 32'h200, "");
        cyc(1, 0, 4'h0, 0, 32'h200, "R9");
        // R7: write to masked view ignored; masked read
        cyc(1, 1, 4'h2, 32'hFFFF_0200, 32'h200, "");
        cyc(1, 1, 4'h3, 32'h0, 32'h200, "R7");
        cyc(1, 0, 4'h3, 0, 32'h200, "R7");
        cyc(1, 0, 4'h2, 0, 32'h200, "R7");
        // R8: unmapped offsets
        cyc(1, 1, 4'h9, 32'h0, 32'h200, "R8");
        cyc(1, 0, 4'hF, 0, 32'h200, "R8");
        cyc(1, 0, 4'h0, 0, 32'h200, "R8");
        cyc(1, 0, 4'h2, 0, 32'h200, "R8");
        // random mix
        for (int i = 0; i < 3000; i++) begin
            logic [31:0] s;
            logic [3:0]  a;
            s = src;
            if ($urandom_range(0, 2) == 0) s = s ^ (32'h1 << $urandom_range(0, 31));
            a = ($urandom_range(0, 7) == 0) ? 4'($urandom_range(4, 15))
                                            : 4'($urandom_range(0, 3));
            cyc($urandom_range(0, 3) != 0, $urandom_range(0, 1) == 1, a,
                $urandom() & $urandom(), s, "");
        end
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule